// File: doc/BRIEF.md
# Sixteen-Function Byte Arithmetic/Logic Unit

This block is a purely combinational arithmetic/logic unit for a byte-wide datapath. It takes two operands, a four-bit function code and a carry input. It returns a result byte and four status outputs: negative, zero, overflow and carry. A surrounding datapath picks the function code each cycle and decides whether to latch the status outputs into flag registers of its own.

The sixteen function codes cover these operations:
- a pass of the first operand;
- four adder forms: plain sum, sum with carry, two's-complement difference, and difference with borrow through the carry input;
- six bitwise forms, including the complements;
- one-place shifts and rotates of the first operand;
- a code that clears the result and copies four low operand bits straight onto the status outputs, so that a saved flag nibble can be reloaded.

Every code has a fixed rule for its flags. The operand width is a parameter, with a default of 8.

Top module: `byte_alu`

## Requirements
- R1: Code 0 drives the result with operand A. Overflow and carry are 0.
- R2: Code 1 gives A+B and code 2 gives A+B+carry_in. The carry output is the bit carried out of the most significant position.
- R3: Code 3 gives A+~B+1 and code 4 gives A+~B+carry_in. The carry output is the adder's own carry-out, not an inverted borrow. For example, 5-3 sets carry to 1 and 3-5 sets it to 0.
- R4: For codes 1 to 4, overflow is 1 exactly when both adder inputs (A and the B or ~B actually added) share a sign bit and the result's sign bit differs from it.
- R5: The bitwise codes give these results: 5 is A AND B, 6 is NAND, 7 is OR, 8 is NOR, 9 is XOR and 10 is NOT A. Overflow and carry are 0 for all six, whatever carry_in is.
- R6: For codes 0 to 14, negative equals the result's most significant bit, and zero is 1 exactly when every result bit is 0.
- R7: Code 11 shifts A left one place and fills the low bit with 0. Code 12 does the same but fills the low bit with carry_in. For both, carry is A's old most significant bit, and overflow is 1 when the top two bits of A differ.
- R8: Code 13 shifts A right one place and keeps the sign bit. Code 14 does the same but fills the top bit with carry_in. For both, carry is A's old bit 0 and overflow is 0.
- R9: Code 15 drives the result to 0. The status outputs come from A's low nibble, counting bit 0 as least significant: negative from A[3], zero from A[2], overflow from A[1] and carry from A[0]. So the zero output can be 0 while the result is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 8 | First operand; the one that is shifted and passed through |
| b_in | input | 8 | Second operand |
| fn_sel | input | 4 | Function code 0 to 15 |
| carry_in | input | 1 | Carry input for codes 2, 4, 12 and 14 |
| result_o | output | 8 | Result byte |
| neg_o | output | 1 | Negative status |
| zero_o | output | 1 | Zero status |
| ovf_o | output | 1 | Overflow status |
| cout_o | output | 1 | Carry status |

## Verification
The assertions are immediate checks evaluated whenever the inputs change. They assume that all inputs are known, two-state values once driven, and they do nothing while the function code is still unknown. The stimulus drives all four inputs together from one task, then waits a settle delay before the outputs are sampled. Every code is driven at least once. Operand values are chosen at the sign, carry and all-zero boundaries, including a code-15 operand whose low nibble is zero.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [3:0] {
    FN_PASS = 4'd0,  FN_ADD  = 4'd1,  FN_ADC  = 4'd2,  FN_SUB  = 4'd3,
    FN_SBC  = 4'd4,  FN_AND  = 4'd5,  FN_NAND = 4'd6,  FN_OR   = 4'd7,
    FN_NOR  = 4'd8,  FN_XOR  = 4'd9,  FN_NOTA = 4'd10, FN_ASL  = 4'd11,
    FN_ROL  = 4'd12, FN_ASR  = 4'd13, FN_ROR  = 4'd14, FN_FLAG = 4'd15
  } alu_fn_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } alu_flags_t;
endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         c_in,
  output logic [W-1:0] sum,
  output logic         c_out,
  output logic         ovf
);
  localparam int MSB = W - 1;
  logic [W:0] wide;

  always_comb begin
    wide  = {1'b0, op_a} + {1'b0, op_b} + {{W{1'b0}}, c_in};
    sum   = wide[W-1:0];
    c_out = wide[W];
    ovf   = (op_a[MSB] == op_b[MSB]) && (wide[MSB] != op_a[MSB]);
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int W = 8
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [3:0]   fn,
  output logic [W-1:0] res
);
  import alu_pkg::*;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      unique case (alu_fn_e'(fn))
        FN_AND:  res[i] = op_a[i] & op_b[i];
        FN_NAND: res[i] = ~(op_a[i] & op_b[i]);
        FN_OR:   res[i] = op_a[i] | op_b[i];
        FN_NOR:  res[i] = ~(op_a[i] | op_b[i]);
        FN_XOR:  res[i] = op_a[i] ^ op_b[i];
        FN_NOTA: res[i] = ~op_a[i];
        default: res[i] = op_a[i];
      endcase
    end
  end
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int W = 8
) (
  input  logic [W-1:0] op_a,
  input  logic         c_in,
  input  logic         go_left,
  input  logic         rotate,
  output logic [W-1:0] res,
  output logic         c_out,
  output logic         ovf
);
  localparam int MSB = W - 1;
  logic fill;

  always_comb begin
    if (go_left) begin
      fill  = rotate ? c_in : 1'b0;
      res   = {op_a[MSB-1:0], fill};
      c_out = op_a[MSB];
      ovf   = op_a[MSB] ^ op_a[MSB-1];
    end else begin
      fill  = rotate ? c_in : op_a[MSB];
      res   = {fill, op_a[MSB:1]};
      c_out = op_a[0];
      ovf   = 1'b0;
    end
  end
endmodule

// File: rtl/byte_alu.sv
module byte_alu #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic [3:0]   fn_sel,
  input  logic         carry_in,
  output logic [W-1:0] result_o,
  output logic         neg_o,
  output logic         zero_o,
  output logic         ovf_o,
  output logic         cout_o
);
  import alu_pkg::*;

  localparam int MSB = W - 1;

  alu_fn_e    fn;
  logic       invert_b;
  logic       add_cin;
  logic [W-1:0] add_b;
  logic [W-1:0] add_sum, log_res, sh_res;
  logic       add_c, add_v, sh_c, sh_v;
  logic       sh_left, sh_rot;
  alu_flags_t flags;

  assign fn = alu_fn_e'(fn_sel);

  always_comb begin
    invert_b = (fn == FN_SUB) || (fn == FN_SBC);
    add_b    = invert_b ? ~b_in : b_in;
    unique case (fn)
      FN_ADC, FN_SBC: add_cin = carry_in;
      FN_SUB:         add_cin = 1'b1;
      default:        add_cin = 1'b0;
    endcase
    sh_left = (fn == FN_ASL) || (fn == FN_ROL);
    sh_rot  = (fn == FN_ROL) || (fn == FN_ROR);
  end

  alu_adder #(.W(W)) u_add (
    .op_a (a_in), .op_b (add_b), .c_in (add_cin),
    .sum  (add_sum), .c_out (add_c), .ovf (add_v)
  );

  alu_logic #(.W(W)) u_log (
    .op_a (a_in), .op_b (b_in), .fn (fn_sel), .res (log_res)
  );

  alu_shift #(.W(W)) u_sh (
    .op_a (a_in), .c_in (carry_in), .go_left (sh_left), .rotate (sh_rot),
    .res  (sh_res), .c_out (sh_c), .ovf (sh_v)
  );

  always_comb begin
    result_o = a_in;
    flags    = '0;
    unique case (fn)
      FN_PASS: result_o = a_in;
      FN_ADD, FN_ADC, FN_SUB, FN_SBC: begin
        result_o = add_sum;
        flags.v  = add_v;
        flags.c  = add_c;
      end
      FN_AND, FN_NAND, FN_OR, FN_NOR, FN_XOR, FN_NOTA: result_o = log_res;
      FN_ASL, FN_ROL, FN_ASR, FN_ROR: begin
        result_o = sh_res;
        flags.v  = sh_v;
        flags.c  = sh_c;
      end
      FN_FLAG: result_o = '0;
      default: result_o = a_in;
    endcase
    if (fn == FN_FLAG) begin
      flags = alu_flags_t'(a_in[3:0]);
    end else begin
      flags.n = result_o[MSB];
      flags.z = ~|result_o;
    end
    neg_o  = flags.n;
    zero_o = flags.z;
    ovf_o  = flags.v;
    cout_o = flags.c;
  end
endmodule

// File: rtl/alu_checker.sv
module alu_checker #(
  parameter int W = 8
) (
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic [3:0]   fn_sel,
  input logic         carry_in,
  input logic [W-1:0] result_o,
  input logic         neg_o,
  input logic         zero_o,
  input logic         ovf_o,
  input logic         cout_o
);
  localparam int MSB = W - 1;
  logic [W:0] ref_add;

  always_comb begin
    ref_add = {1'b0, a_in} + {1'b0, b_in};
    if (fn_sel == 4'd0) begin
      a_r1_pass: assert (result_o == a_in && !ovf_o && !cout_o);
    end
    if (fn_sel == 4'd1) begin
      a_r2_add_sum: assert ({cout_o, result_o} == ref_add);
    end
    if (fn_sel >= 4'd5 && fn_sel <= 4'd10) begin
      a_r5_logic_vc_clear: assert (!ovf_o && !cout_o);
    end
    if (fn_sel != 4'd15) begin
      a_r6_neg_msb: assert (neg_o == result_o[MSB]);
      a_r6_zero_flag: assert (zero_o == (result_o == '0));
    end
    if (fn_sel == 4'd11 || fn_sel == 4'd12) begin
      a_r7_shl_carry: assert (cout_o == a_in[MSB]);
    end
    if (fn_sel == 4'd13 || fn_sel == 4'd14) begin
      a_r8_shr_flags: assert (!ovf_o && cout_o == a_in[0]);
    end
    if (fn_sel == 4'd15) begin
      a_r9_flag_load: assert (result_o == '0 &&
                              {neg_o, zero_o, ovf_o, cout_o} == a_in[3:0]);
    end
  end
endmodule

bind byte_alu alu_checker #(.W(W)) u_chk (
  .a_in (a_in), .b_in (b_in), .fn_sel (fn_sel), .carry_in (carry_in),
  .result_o (result_o), .neg_o (neg_o), .zero_o (zero_o),
  .ovf_o (ovf_o), .cout_o (cout_o)
);

// File: tb/tb_byte_alu.sv
module tb_byte_alu;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic [7:0] a_in, b_in, result_o;
  logic [3:0] fn_sel;
  logic       carry_in, neg_o, zero_o, ovf_o, cout_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  byte_alu dut (
    .a_in (a_in), .b_in (b_in), .fn_sel (fn_sel), .carry_in (carry_in),
    .result_o (result_o), .neg_o (neg_o), .zero_o (zero_o),
    .ovf_o (ovf_o), .cout_o (cout_o)
  );

  // expected packed as {result, N, Z, V, C}
  task automatic run(input string req, input logic [3:0] f, input logic [7:0] a,
                     input logic [7:0] b, input logic ci, input logic [11:0] exp);
    logic [11:0] got;
    fn_sel = f; a_in = a; b_in = b; carry_in = ci;
    #(CLK_PERIOD/2);
    got = {result_o, neg_o, zero_o, ovf_o, cout_o};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s fn=%0d a=%h b=%h cin=%b actual=%h expected=%h",
               req, f, a, b, ci, got, exp);
    end
    #(CLK_PERIOD/2);
  endtask

  task automatic t_pass();
    run("R1", 4'd0, 8'h00, 8'h55, 1'b1, {8'h00, 4'b0100});
    run("R1", 4'd0, 8'h80, 8'hFF, 1'b1, {8'h80, 4'b1000});
  endtask

  task automatic t_add();
    run("R2", 4'd1, 8'hFF, 8'h01, 1'b0, {8'h00, 4'b0101});
    run("R2", 4'd2, 8'h10, 8'h20, 1'b1, {8'h31, 4'b0000});
    run("R2", 4'd1, 8'h10, 8'h20, 1'b1, {8'h30, 4'b0000});
  endtask

  task automatic t_sub();
    run("R3", 4'd3, 8'h05, 8'h03, 1'b0, {8'h02, 4'b0001});
    run("R3", 4'd3, 8'h03, 8'h05, 1'b0, {8'hFE, 4'b1000});
    run("R3", 4'd4, 8'h05, 8'h05, 1'b0, {8'hFF, 4'b1000});
    run("R3", 4'd4, 8'h05, 8'h05, 1'b1, {8'h00, 4'b0101});
  endtask

  task automatic t_ovf();
    run("R4", 4'd1, 8'h7F, 8'h01, 1'b0, {8'h80, 4'b1010});
    run("R4", 4'd3, 8'h80, 8'h01, 1'b0, {8'h7F, 4'b0011});
    run("R4", 4'd1, 8'h80, 8'h80, 1'b0, {8'h00, 4'b0111});
  endtask

  task automatic t_logic();
    run("R5", 4'd5,  8'hF0, 8'h3C, 1'b1, {8'h30, 4'b0000});
    run("R5", 4'd6,  8'hF0, 8'h3C, 1'b1, {8'hCF, 4'b1000});
    run("R5", 4'd7,  8'hF0, 8'h3C, 1'b1, {8'hFC, 4'b1000});
    run("R5", 4'd8,  8'hF0, 8'h3C, 1'b1, {8'h03, 4'b0000});
    run("R5", 4'd9,  8'hF0, 8'h3C, 1'b1, {8'hCC, 4'b1000});
    run("R5", 4'd10, 8'hFF, 8'h00, 1'b1, {8'h00, 4'b0100});
  endtask

  task automatic t_flags();
    run("R6", 4'd9, 8'hA5, 8'hA5, 1'b0, {8'h00, 4'b0100});
    run("R6", 4'd7, 8'h01, 8'h80, 1'b0, {8'h81, 4'b1000});
  endtask

  task automatic t_left();
    run("R7", 4'd11, 8'h40, 8'h00, 1'b1, {8'h80, 4'b1010});
    run("R7", 4'd11, 8'h81, 8'h00, 1'b1, {8'h02, 4'b0011});
    run("R7", 4'd12, 8'h81, 8'h00, 1'b1, {8'h03, 4'b0011});
    run("R7", 4'd12, 8'hC0, 8'h00, 1'b0, {8'h80, 4'b1001});
  endtask

  task automatic t_right();
    run("R8", 4'd13, 8'h81, 8'h00, 1'b0, {8'hC0, 4'b1001});
    run("R8", 4'd13, 8'h01, 8'h00, 1'b1, {8'h00, 4'b0101});
    run("R8", 4'd14, 8'h02, 8'h00, 1'b1, {8'h81, 4'b1000});
    run("R8", 4'd14, 8'h81, 8'h00, 1'b0, {8'h40, 4'b0001});
  endtask

  task automatic t_flagload();
    run("R9", 4'd15, 8'h0A, 8'hFF, 1'b1, {8'h00, 4'b1010});
    run("R9", 4'd15, 8'hF5, 8'hFF, 1'b0, {8'h00, 4'b0101});
    run("R9", 4'd15, 8'hF0, 8'h00, 1'b1, {8'h00, 4'b0000});
  endtask

  initial begin
    fn_sel = 4'd0; a_in = '0; b_in = '0; carry_in = 1'b0;
    #(CLK_PERIOD);
    t_pass();
    t_add();
    t_sub();
    t_ovf();
    t_logic();
    t_flags();
    t_left();
    t_right();
    t_flagload();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule